// File: doc/BRIEF.md
# Overcurrent Fault Guard

This block is the digital half of battery-pack overcurrent protection. Each clock it receives a signed sense voltage in millivolts, where a positive value means discharge current and a negative value means charge current. It also receives a single-cycle strobe from a 32 kHz timebase. Three detectors run side by side: overload, which only looks at discharge current; short circuit in the discharge direction; and short circuit in the charge direction. Each detector has its own programmable threshold, hysteresis band and debounce delay, and each can be switched off on its own.

When a detector's delay runs out, the block latches a sticky status bit. While any status bit is set, it forces the discharge, charge and zero-volt-charge FET enables off and pulls an active-low alert low. The host clears the latch by taking a clear bit from 0 to 1 and back to 0. If the condition is still present at that point, the fault stays latched. When no fault is latched, the host's three FET control bits pass straight through to the enables.

Top module: `oc_fault_guard`

## Requirements
- R1: After synchronous reset, `status` is 000 and `alert_n` is 1, and the FET enables follow the host bits.
- R2: The overload threshold is 50 + 5·`ol_thr_sel` mV (codes 0..31). Overload arms only when `sense_mv` is strictly greater than the threshold, so a zero or negative (charge) sample never sets it.
- R3: Both short-circuit thresholds are 100 + 25·code mV (codes 0..15), each with its own code. The discharge detector arms when `sense_mv` ≥ its threshold. The charge detector arms when −`sense_mv` ≥ its threshold.
- R4: The overload delay is TICKS_PER_MS·(1 + 2·`ol_dly_sel`) timebase ticks, which is 32·(1+2·code) at default. With `slow_tick` high every cycle, the status bit sets on the clock edge that follows that many counting edges. Cycles where `slow_tick` is low do not advance the delay.
- R5: The short-circuit delay is SC_TICKS_PER_STEP·code ticks, which is 2·code at default. With code 0, the status bit sets on the first clock edge at which the sample meets the threshold.
- R6: Once armed, a detector keeps counting while the sample stays at or above its threshold minus the hysteresis (10 mV for overload, 50 mV for short circuit). A sample below that level restarts the delay from zero.
- R7: While any status bit is set, `dsg_en`, `chg_en` and `zvchg_en` are 0 and `alert_n` is 0.
- R8: The status bits are sticky. Bit 0 is the discharge short circuit, bit 1 is the charge short circuit, and bit 2 is overload. Several bits can be set together.
- R9: A 1 on `flt_clr` followed by a 0 clears `status` on the edge where the 0 is first sampled. A fault that still qualifies at that edge stays set.
- R10: `ol_off`, `scc_off` and `scd_off` each stop the matching detector from ever setting its bit. The other detectors are unaffected.
- R11: With no fault latched, `dsg_en` = `host_dsg_on`, `chg_en` = `host_chg_on`, and `zvchg_en` = NOT `host_zv_off` (1 on `host_zv_off` turns that FET off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle 32 kHz timebase strobe |
| sense_mv | input | SENSE_W | Signed sense voltage in mV, positive = discharge |
| ol_thr_sel | input | 5 | Overload threshold code |
| ol_dly_sel | input | 4 | Overload delay code |
| scd_thr_sel | input | 4 | Discharge short-circuit threshold code |
| scd_dly_sel | input | 4 | Discharge short-circuit delay code |
| scc_thr_sel | input | 4 | Charge short-circuit threshold code |
| scc_dly_sel | input | 4 | Charge short-circuit delay code |
| ol_off | input | 1 | Disable overload detector |
| scd_off | input | 1 | Disable discharge short-circuit detector |
| scc_off | input | 1 | Disable charge short-circuit detector |
| host_dsg_on | input | 1 | Host request: discharge FET on |
| host_chg_on | input | 1 | Host request: charge FET on |
| host_zv_off | input | 1 | Host request, active low: 1 turns zero-volt-charge FET off |
| flt_clr | input | 1 | Fault clear; a 1 then 0 clears the latch |
| dsg_en | output | 1 | Discharge FET enable |
| chg_en | output | 1 | Charge FET enable |
| zvchg_en | output | 1 | Zero-volt-charge FET enable |
| status | output | 3 | Sticky fault bits {overload, charge SC, discharge SC} |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench holds the timebase strobe high, so a detector with a delay of D ticks sets its status bit exactly D+1 clock edges after the arming sample is applied. The bench checks the bit is still clear after D edges and set after D+1. The FET enables and `alert_n` are combinational from the status register and the host bits, so they are checked a fraction of a cycle after the inputs change. A clear takes effect on the second edge after `flt_clr` rises, and the bench reads the status one edge later. All inputs are driven on the falling clock edge and all outputs are sampled just after it.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    localparam int LVL_W     = 14;
    localparam int OL_BASE   = 50;
    localparam int OL_STEP   = 5;
    localparam int OL_HYST   = 10;
    localparam int SC_BASE   = 100;
    localparam int SC_STEP   = 25;
    localparam int SC_HYST   = 50;
    localparam int NUM_DET   = 3;

    typedef logic signed [LVL_W-1:0] lvl_t;

    // bit 2 overload, bit 1 charge short, bit 0 discharge short
    typedef struct packed {
        logic ol;
        logic sc_chg;
        logic sc_dsg;
    } flt_t;

    function automatic lvl_t ol_thr(input logic [4:0] code);
        return lvl_t'(OL_BASE + OL_STEP * int'(code));
    endfunction

    function automatic lvl_t sc_thr(input logic [3:0] code);
        return lvl_t'(SC_BASE + SC_STEP * int'(code));
    endfunction

endpackage

// File: rtl/oc_delay_qual.sv
module oc_delay_qual
    import oc_guard_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter bit STRICT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  lvl_t             level,
    input  lvl_t             thr,
    input  lvl_t             hyst,
    input  logic [CNT_W-1:0] dly,
    output logic             fire
);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             over;
    logic             hold;
    logic             engaged;
    lvl_t             floor_lvl;

    // the comparison kind is picked per instance
    generate
        if (STRICT) begin : g_gt
            assign over = (level > thr);
        end else begin : g_ge
            assign over = (level >= thr);
        end
    endgenerate

    always_comb begin
        floor_lvl = thr - hyst;
        hold      = (level >= floor_lvl);
        engaged   = en && hold && (active_q || over);
        fire      = engaged && (cnt_q >= dly);
    end

    always_ff @(posedge clk) begin
        if (rst || !engaged) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            active_q <= 1'b1;
            if (tick && (cnt_q < dly)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch
    import oc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  flt_t fire,
    output flt_t stat
);

    logic               clr_q;
    logic               clr_fall;
    logic [NUM_DET-1:0] keep_v;

    assign clr_fall = clr_q & ~clr;
    assign keep_v   = clr_fall ? '0 : stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= 1'b0;
            stat  <= '0;
        end else begin
            clr_q <= clr;
            // a qualifying fault wins over the clear
            stat  <= flt_t'(keep_v | fire);
        end
    end

endmodule

// File: rtl/oc_fault_guard.sv
module oc_fault_guard
    import oc_guard_pkg::*;
#(
    parameter int SENSE_W           = 12,
    parameter int TICKS_PER_MS      = 32,
    parameter int SC_TICKS_PER_STEP = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      slow_tick,
    input  logic signed [SENSE_W-1:0] sense_mv,
    input  logic [4:0]                ol_thr_sel,
    input  logic [3:0]                ol_dly_sel,
    input  logic [3:0]                scd_thr_sel,
    input  logic [3:0]                scd_dly_sel,
    input  logic [3:0]                scc_thr_sel,
    input  logic [3:0]                scc_dly_sel,
    input  logic                      ol_off,
    input  logic                      scd_off,
    input  logic                      scc_off,
    input  logic                      host_dsg_on,
    input  logic                      host_chg_on,
    input  logic                      host_zv_off,
    input  logic                      flt_clr,
    output logic                      dsg_en,
    output logic                      chg_en,
    output logic                      zvchg_en,
    output logic [2:0]                status,
    output logic                      alert_n
);

    localparam int OL_MAX  = TICKS_PER_MS * 31;
    localparam int SC_MAX  = SC_TICKS_PER_STEP * 15;
    localparam int DLY_MAX = (OL_MAX > SC_MAX) ? OL_MAX : SC_MAX;
    localparam int CNT_W   = $clog2(DLY_MAX + 1);
    localparam int OL_IDX  = 2;

    lvl_t             lvl_dsg;
    lvl_t             lvl_a  [NUM_DET];
    lvl_t             thr_a  [NUM_DET];
    lvl_t             hyst_a [NUM_DET];
    logic [CNT_W-1:0] dly_a  [NUM_DET];
    logic             en_a   [NUM_DET];
    logic [NUM_DET-1:0] fire_v;
    flt_t             stat;
    logic             faulted;

    always_comb begin
        lvl_dsg    = lvl_t'(sense_mv);
        // discharge short circuit
        lvl_a[0]   = lvl_dsg;
        thr_a[0]   = sc_thr(scd_thr_sel);
        hyst_a[0]  = lvl_t'(SC_HYST);
        dly_a[0]   = CNT_W'(SC_TICKS_PER_STEP * int'(scd_dly_sel));
        en_a[0]    = !scd_off;
        // charge short circuit, magnitude of negative sense
        lvl_a[1]   = -lvl_dsg;
        thr_a[1]   = sc_thr(scc_thr_sel);
        hyst_a[1]  = lvl_t'(SC_HYST);
        dly_a[1]   = CNT_W'(SC_TICKS_PER_STEP * int'(scc_dly_sel));
        en_a[1]    = !scc_off;
        // overload, discharge only
        lvl_a[2]   = lvl_dsg;
        thr_a[2]   = ol_thr(ol_thr_sel);
        hyst_a[2]  = lvl_t'(OL_HYST);
        dly_a[2]   = CNT_W'(TICKS_PER_MS * (1 + 2 * int'(ol_dly_sel)));
        en_a[2]    = !ol_off;
    end

    generate
        for (genvar i = 0; i < NUM_DET; i++) begin : g_det
            oc_delay_qual #(
                .CNT_W  (CNT_W),
                .STRICT (i == OL_IDX)
            ) u_qual (
                .clk   (clk),
                .rst   (rst),
                .en    (en_a[i]),
                .tick  (slow_tick),
                .level (lvl_a[i]),
                .thr   (thr_a[i]),
                .hyst  (hyst_a[i]),
                .dly   (dly_a[i]),
                .fire  (fire_v[i])
            );
        end
    endgenerate

    oc_fault_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .clr  (flt_clr),
        .fire (flt_t'(fire_v)),
        .stat (stat)
    );

    assign faulted  = |stat;
    assign status   = stat;
    assign alert_n  = ~faulted;
    assign dsg_en   = host_dsg_on & ~faulted;
    assign chg_en   = host_chg_on & ~faulted;
    assign zvchg_en = ~host_zv_off & ~faulted;

endmodule

// File: rtl/oc_fault_chk.sv
module oc_fault_chk #(
    parameter int SENSE_W = 12
) (
    input logic                      clk,
    input logic                      rst,
    input logic signed [SENSE_W-1:0] sense_mv,
    input logic                      ol_off,
    input logic                      scd_off,
    input logic                      scc_off,
    input logic                      host_dsg_on,
    input logic                      host_chg_on,
    input logic                      host_zv_off,
    input logic                      flt_clr,
    input logic                      dsg_en,
    input logic                      chg_en,
    input logic                      zvchg_en,
    input logic [2:0]                status,
    input logic                      alert_n
);

    logic clr_prev;

    always_ff @(posedge clk) begin
        if (rst) clr_prev <= 1'b0;
        else     clr_prev <= flt_clr;
    end

    // R7: any latched bit forces all drives off and the alert low
    a_r7_drives_off: assert property (@(posedge clk) disable iff (rst)
        (status != 3'b000) |-> (!dsg_en && !chg_en && !zvchg_en && !alert_n));

    // R8 / R9: latched bits survive every edge that is not a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !(clr_prev && !flt_clr) |=> ((status & $past(status)) == $past(status)));

    // R10: a disabled detector never raises its bit
    a_r10_ol_off: assert property (@(posedge clk) disable iff (rst)
        ol_off |=> !$rose(status[2]));
    a_r10_scd_off: assert property (@(posedge clk) disable iff (rst)
        scd_off |=> !$rose(status[0]));
    a_r10_scc_off: assert property (@(posedge clk) disable iff (rst)
        scc_off |=> !$rose(status[1]));

    // R2: overload never arms from a zero or charge-direction sample
    a_r2_dsg_only: assert property (@(posedge clk) disable iff (rst)
        (sense_mv <= 0) |=> !$rose(status[2]));

    // R11: host bits pass through with no latched fault
    a_r11_pass: assert property (@(posedge clk) disable iff (rst)
        (status == 3'b000) |-> (dsg_en == host_dsg_on && chg_en == host_chg_on
                                && zvchg_en == !host_zv_off && alert_n));

endmodule

bind oc_fault_guard oc_fault_chk #(.SENSE_W(SENSE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sense_mv    (sense_mv),
    .ol_off      (ol_off),
    .scd_off     (scd_off),
    .scc_off     (scc_off),
    .host_dsg_on (host_dsg_on),
    .host_chg_on (host_chg_on),
    .host_zv_off (host_zv_off),
    .flt_clr     (flt_clr),
    .dsg_en      (dsg_en),
    .chg_en      (chg_en),
    .zvchg_en    (zvchg_en),
    .status      (status),
    .alert_n     (alert_n)
);

// File: tb/oc_fault_guard_tb.sv
module oc_fault_guard_tb_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               slow_tick = 1'b1;
    logic signed [11:0] sense_mv = '0;
    logic [4:0]         ol_thr_sel = '0;
    logic [3:0]         ol_dly_sel = '0;
    logic [3:0]         scd_thr_sel = '0;
    logic [3:0]         scd_dly_sel = '0;
    logic [3:0]         scc_thr_sel = '0;
    logic [3:0]         scc_dly_sel = '0;
    logic               ol_off = 1'b0;
    logic               scd_off = 1'b0;
    logic               scc_off = 1'b0;
    logic               host_dsg_on = 1'b1;
    logic               host_chg_on = 1'b1;
    logic               host_zv_off = 1'b1;
    logic               flt_clr = 1'b0;
    logic               dsg_en;
    logic               chg_en;
    logic               zvchg_en;
    logic [2:0]         status;
    logic               alert_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    oc_fault_guard dut_i (
        .clk         (clk),
        .rst         (rst),
        .slow_tick   (slow_tick),
        .sense_mv    (sense_mv),
        .ol_thr_sel  (ol_thr_sel),
        .ol_dly_sel  (ol_dly_sel),
        .scd_thr_sel (scd_thr_sel),
        .scd_dly_sel (scd_dly_sel),
        .scc_thr_sel (scc_thr_sel),
        .scc_dly_sel (scc_dly_sel),
        .ol_off      (ol_off),
        .scd_off     (scd_off),
        .scc_off     (scc_off),
        .host_dsg_on (host_dsg_on),
        .host_chg_on (host_chg_on),
        .host_zv_off (host_zv_off),
        .flt_clr     (flt_clr),
        .dsg_en      (dsg_en),
        .chg_en      (chg_en),
        .zvchg_en    (zvchg_en),
        .status      (status),
        .alert_n     (alert_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_clear();
        sense_mv = '0;
        flt_clr  = 1'b1;
        step(1);
        flt_clr  = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 alert_n", int'(alert_n), 1);
        chk("R1 dsg_en", int'(dsg_en), 1);

        // R11 host pass-through, all combinations
        for (int h = 0; h < 8; h++) begin
            {host_dsg_on, host_chg_on, host_zv_off} = 3'(h);
            #1;
            chk("R11 pass", int'({dsg_en, chg_en, zvchg_en}),
                int'({host_dsg_on, host_chg_on, !host_zv_off}));
        end
        host_dsg_on = 1'b1; host_chg_on = 1'b1; host_zv_off = 1'b0;

        // R2 overload threshold sweep, delay code 0 = 32 ticks
        scd_off = 1'b1;
        for (int c = 0; c < 32; c++) begin
            ol_thr_sel = 5'(c);
            sense_mv   = 12'(50 + 5 * c);
            step(40);
            chk("R2 equal no trip", int'(status), 0);
            sense_mv = 12'(51 + 5 * c);
            step(32);
            chk("R4 not yet", int'(status), 0);
            step(1);
            chk("R2 over trips", int'(status), 4);
            if (c == 0) begin
                chk("R7 fets off", int'({dsg_en, chg_en, zvchg_en}), 0);
                chk("R7 alert", int'(alert_n), 0);
            end
            do_clear();
            chk("R9 cleared", int'(status), 0);
        end
        ol_thr_sel = '0;

        // R2 charge direction never overloads
        scc_off  = 1'b1;
        sense_mv = -12'sd300;
        step(100);
        chk("R2 charge ignored", int'(status), 0);
        sense_mv = '0;
        step(1);

        // R3 short-circuit threshold sweep, delay 0, both directions
        ol_off = 1'b1; scd_off = 1'b0; scc_off = 1'b0;
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 2; d++) begin
                scd_thr_sel = 4'(c);
                scc_thr_sel = 4'(c);
                sense_mv = (d == 0) ? 12'(99 + 25 * c) : -12'(99 + 25 * c);
                step(3);
                chk("R3 below", int'(status), 0);
                sense_mv = (d == 0) ? 12'(100 + 25 * c) : -12'(100 + 25 * c);
                step(1);
                chk("R3 at threshold", int'(status), (d == 0) ? 1 : 2);
                do_clear();
            end
        end
        scd_thr_sel = '0; scc_thr_sel = '0;

        // R5 discharge short-circuit delay sweep
        for (int c = 0; c < 16; c++) begin
            scd_dly_sel = 4'(c);
            sense_mv    = 12'sd150;
            if (c > 0) begin
                step(2 * c);
                chk("R5 not yet", int'(status), 0);
            end
            step(1);
            chk("R5 delay", int'(status), 1);
            do_clear();
        end
        scd_dly_sel = '0;

        // R4 overload delay sweep
        ol_off = 1'b0; scd_off = 1'b1; scc_off = 1'b1;
        for (int c = 0; c < 16; c++) begin
            ol_dly_sel = 4'(c);
            sense_mv   = 12'sd100;
            step(32 * (1 + 2 * c));
            chk("R4 not yet", int'(status), 0);
            step(1);
            chk("R4 delay", int'(status), 4);
            do_clear();
        end
        ol_dly_sel = '0;

        // R4 idle tick freezes the delay
        slow_tick = 1'b0;
        sense_mv  = 12'sd100;
        step(200);
        chk("R4 no tick", int'(status), 0);
        slow_tick = 1'b1;
        step(32);
        chk("R4 resumed not yet", int'(status), 0);
        step(1);
        chk("R4 resumed", int'(status), 4);
        do_clear();

        // R6 overload hysteresis: 41 holds, 39 restarts
        sense_mv = 12'sd60; step(10);
        sense_mv = 12'sd41; step(22);
        chk("R6 ol hold", int'(status), 0);
        step(1);
        chk("R6 ol hold trips", int'(status), 4);
        do_clear();
        sense_mv = 12'sd60; step(10);
        sense_mv = 12'sd39; step(1);
        sense_mv = 12'sd60; step(32);
        chk("R6 ol restart", int'(status), 0);
        step(1);
        chk("R6 ol restart trips", int'(status), 4);
        do_clear();

        // R6 short-circuit hysteresis, 4-tick delay
        ol_off = 1'b1; scd_off = 1'b0; scd_dly_sel = 4'd2;
        sense_mv = 12'sd100; step(2);
        sense_mv = 12'sd55;  step(2);
        chk("R6 sc hold", int'(status), 0);
        step(1);
        chk("R6 sc hold trips", int'(status), 1);
        do_clear();
        sense_mv = 12'sd100; step(2);
        sense_mv = 12'sd49;  step(1);
        sense_mv = 12'sd100; step(4);
        chk("R6 sc restart", int'(status), 0);
        step(1);
        chk("R6 sc restart trips", int'(status), 1);
        do_clear();
        scd_dly_sel = '0;

        // R10 all detectors disabled
        ol_off = 1'b1; scd_off = 1'b1; scc_off = 1'b1;
        sense_mv = 12'sd400; step(100);
        chk("R10 all off dsg", int'(status), 0);
        sense_mv = -12'sd400; step(20);
        chk("R10 all off chg", int'(status), 0);
        // R10 only discharge short off: overload alone sets
        ol_off = 1'b0;
        sense_mv = 12'sd150; step(40);
        chk("R10 scd off only", int'(status), 4);
        do_clear();

        // R8 two bits together
        scd_off = 1'b0;
        sense_mv = 12'sd400; step(1);
        chk("R8 sc first", int'(status), 1);
        step(32);
        chk("R8 both bits", int'(status), 5);
        // R9 clear while fault persists
        flt_clr = 1'b1; step(1);
        chk("R9 held clear", int'(status), 5);
        flt_clr = 1'b0; step(2);
        chk("R9 persists", int'(status), 5);
        do_clear();
        chk("R9 gone", int'(status), 0);
        host_zv_off = 1'b1; #1;
        chk("R11 after clear", int'({dsg_en, chg_en, zvchg_en, alert_n}), 4'b1101);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule